// File: doc/BRIEF.md
# Block Control Word Decoder and Row Sequencer

This block sits on the receive side of a link that moves image blocks into a micromirror array. Each block transfer starts with a 192-bit control word delivered over a valid/ready handshake. The block checks the word. It drops words that carry a nonzero tag byte or illegal settings, and turns an accepted word into one of three block operations: a row-by-row load, a clear to zeros, or a set to ones.

For a load, the block emits one row index per incoming data beat. Rows count upward from 1 or downward from the last row, as a direction bit selects, and the number of rows comes from the word, so partial blocks are allowed. For a clear or set, it issues one whole-block fill command with its fill value, and the length and direction fields play no part. The target block address, the operation type and the segment selection are held on outputs for the whole operation. A one-cycle done pulse marks the end of the operation. The link layer, the pixel data path and the array timing are handled elsewhere.

Top module: `blkctl_seq`

## Requirements
- R1: `cw_ready` is high exactly when no operation is in progress. A word is taken on a rising edge with `cw_valid` and `cw_ready` both high. After a load or fill word is taken, `cw_ready` stays low until the cycle that carries `op_done`, and a word offered while `cw_ready` is low is neither taken nor acted on.
- R2: A word whose bits [7:0] are not all zero is taken and discarded. No operation starts, `cw_ready` stays high, and `err_count` does not change.
- R3: From the cycle after a load or fill word is taken, `blk_addr` shows bits [11:8] of that word, selecting one of 16 blocks. It holds that value until the next operation starts.
- R4: Bits [34:32] hold the operation code: 000 load, 001 clear, 010 set. `op_type` reports them as 0 load, 1 clear, 2 set. For a load, bits [24:16] give the row count. During the load, `row_valid` is high in each cycle in which `beat` is high, and `row_idx` carries the row for that beat.
- R5: For a load, bit 36 clear gives rows 1, 2, 3 and so on, and bit 36 set gives rows 136, 135, 134 and so on. `row_idx` advances one step on each edge at which a beat is consumed and holds while `beat` is low.
- R6: For a clear or set, `fill_cmd` is high for exactly one cycle, the cycle after the word is taken. `fill_value` is 0 for clear and 1 for set. The row count and bit 36 are ignored, so a count of 0 is accepted.
- R7: `op_done` is a one-cycle pulse. For a load it comes in the cycle after the edge that consumes the last beat. For a fill it comes in the cycle after `fill_cmd`. `cw_ready` is high in that same cycle.
- R8: A load word with a row count of 0 or above 136, or a word with an operation code from 011 to 111, is discarded. `err_count` then rises by one and saturates at its maximum (255 with the default width).
- R9: `single_ch` reports bit 30 of the accepted word. `seg_sel` reports bits [29:28] when bit 30 is set and 00 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cw_data | input | 192 | Control word |
| cw_valid | input | 1 | Control word offered |
| cw_ready | output | 1 | Block idle, word will be taken |
| beat | input | 1 | One data beat (one row) present this cycle |
| blk_addr | output | 4 | Target block of current operation |
| op_type | output | 2 | 0 load, 1 clear, 2 set |
| row_idx | output | 8 | Row index for the current beat |
| row_valid | output | 1 | Row index is in use this cycle |
| fill_cmd | output | 1 | Whole-block fill command |
| fill_value | output | 1 | Value written by the fill |
| seg_sel | output | 2 | Segment, zero unless single-channel |
| single_ch | output | 1 | Single-channel mode flag |
| op_done | output | 1 | Operation finished pulse |
| err_count | output | 8 | Saturating count of rejected words |

## Verification
Words are taken at a rising edge, and every registered result is due in the following cycle. Address, type, segment, first row index, `fill_cmd` and the updated `err_count` all appear then. `row_valid` depends directly on `beat`, so the bench drives inputs on the falling edge and checks it one time step later in the same cycle. `op_done` is checked in the cycle after the last consumed beat, or the cycle after `fill_cmd`, and its absence is checked one cycle later. Random word mixes, random beat gaps and words offered while busy are run against a bench model of the field rules. Directed runs cover single-row loads in both directions, full-length loads, a fill with a zero count, and driving the error counter into saturation.

// File: rtl/blkctl_pkg.sv
package blkctl_pkg;

    localparam int CW_W       = 192;
    localparam int TAG_LSB    = 0;
    localparam int TAG_W      = 8;
    localparam int ADDR_LSB   = 8;
    localparam int ADDR_W     = 4;
    localparam int CNT_LSB    = 16;
    localparam int CNT_W      = 9;
    localparam int SEG_LSB    = 28;
    localparam int SINGLE_BIT = 30;
    localparam int TYPE_LSB   = 32;
    localparam int FLIP_BIT   = 36;
    localparam int ROWS_DEF   = 136;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_SET   = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_FILL = 2'd2
    } state_e;

    typedef enum logic [1:0] {
        V_IGNORE = 2'd0,
        V_ERROR  = 2'd1,
        V_LOAD   = 2'd2,
        V_FILL   = 2'd3
    } verdict_e;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  count;
        logic [1:0]        seg;
        logic              single;
        logic [2:0]        ltype;
        logic              flip;
    } cw_fields_t;

    function automatic cw_fields_t split_word(input logic [CW_W-1:0] w);
        cw_fields_t f;
        f.tag    = w[TAG_LSB +: TAG_W];
        f.addr   = w[ADDR_LSB +: ADDR_W];
        f.count  = w[CNT_LSB +: CNT_W];
        f.seg    = w[SEG_LSB +: 2];
        f.single = w[SINGLE_BIT];
        f.ltype  = w[TYPE_LSB +: 3];
        f.flip   = w[FLIP_BIT];
        return f;
    endfunction

endpackage

// File: rtl/blkctl_decode.sv
module blkctl_decode
    import blkctl_pkg::*;
#(
    parameter int ROWS = ROWS_DEF
) (
    input  logic [CW_W-1:0] word,
    output cw_fields_t      fields,
    output verdict_e        verdict,
    output op_e             op
);

    logic spare_unused;
    assign spare_unused = ^{word[CW_W-1:FLIP_BIT+1], word[FLIP_BIT-1], word[31],
                            word[27:25], word[15:12]};

    assign fields = split_word(word);

    always_comb begin
        op      = OP_LOAD;
        verdict = V_ERROR;
        if (fields.tag != '0) begin
            verdict = V_IGNORE;
        end else begin
            unique case (fields.ltype)
                3'b000: begin
                    op = OP_LOAD;
                    if (fields.count != '0 && int'(fields.count) <= ROWS)
                        verdict = V_LOAD;
                end
                3'b001: begin
                    op      = OP_CLEAR;
                    verdict = V_FILL;
                end
                3'b010: begin
                    op      = OP_SET;
                    verdict = V_FILL;
                end
                default: verdict = V_ERROR;
            endcase
        end
    end

endmodule

// File: rtl/blkctl_rowgen.sv
module blkctl_rowgen
    import blkctl_pkg::*;
#(
    parameter int ROWS  = ROWS_DEF,
    parameter int ROW_W = $clog2(ROWS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             down,
    input  logic [CNT_W-1:0] count,
    input  logic             step,
    output logic [ROW_W-1:0] row,
    output logic             last
);

    localparam logic [ROW_W-1:0] TOP_ROW = ROW_W'(ROWS);
    localparam logic [ROW_W-1:0] BOT_ROW = ROW_W'(1);

    logic [ROW_W-1:0] row_q;
    logic [CNT_W-1:0] left_q;
    logic             dir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q  <= BOT_ROW;
            left_q <= '0;
            dir_q  <= 1'b0;
        end else if (start) begin
            row_q  <= down ? TOP_ROW : BOT_ROW;
            left_q <= count;
            dir_q  <= down;
        end else if (step) begin
            left_q <= left_q - 1'b1;
            row_q  <= dir_q ? row_q - 1'b1 : row_q + 1'b1;
        end
    end

    assign row  = row_q;
    assign last = (left_q == CNT_W'(1));

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
        (step && !last && !start) |=> (row == $past(dir_q ? row_q - 1'b1 : row_q + 1'b1))); // R5

    AST_FIRST_ROW: assert property (@(posedge clk) disable iff (rst)
        start |=> (row == (down_past() ? TOP_ROW : BOT_ROW))); // R5

    function automatic logic down_past();
        return dir_q;
    endfunction

endmodule

// File: rtl/blkctl_seq.sv
module blkctl_seq
    import blkctl_pkg::*;
#(
    parameter int ROWS  = ROWS_DEF,
    parameter int ERR_W = 8,
    parameter int ROW_W = $clog2(ROWS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CW_W-1:0]   cw_data,
    input  logic              cw_valid,
    output logic              cw_ready,
    input  logic              beat,
    output logic [ADDR_W-1:0] blk_addr,
    output logic [1:0]        op_type,
    output logic [ROW_W-1:0]  row_idx,
    output logic              row_valid,
    output logic              fill_cmd,
    output logic              fill_value,
    output logic [1:0]        seg_sel,
    output logic              single_ch,
    output logic              op_done,
    output logic [ERR_W-1:0]  err_count
);

    state_e            state_q;
    cw_fields_t        fld;
    verdict_e          verdict;
    op_e               op_dec;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        seg_q;
    logic              single_q;
    logic              done_q;
    logic [ERR_W-1:0]  err_q;
    logic              accept;
    logic              start_load;
    logic              step;
    logic              last_row;
    logic [ROW_W-1:0]  row_cur;

    blkctl_decode #(.ROWS(ROWS)) u_decode (
        .word    (cw_data),
        .fields  (fld),
        .verdict (verdict),
        .op      (op_dec)
    );

    assign accept     = cw_valid && (state_q == ST_IDLE);
    assign start_load = accept && (verdict == V_LOAD);
    assign step       = (state_q == ST_LOAD) && beat;

    blkctl_rowgen #(.ROWS(ROWS), .ROW_W(ROW_W)) u_rowgen (
        .clk   (clk),
        .rst   (rst),
        .start (start_load),
        .down  (fld.flip),
        .count (fld.count),
        .step  (step),
        .row   (row_cur),
        .last  (last_row)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            op_q     <= OP_LOAD;
            addr_q   <= '0;
            seg_q    <= '0;
            single_q <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (verdict == V_LOAD || verdict == V_FILL) begin
                            state_q  <= (verdict == V_LOAD) ? ST_LOAD : ST_FILL;
                            op_q     <= op_dec;
                            addr_q   <= fld.addr;
                            single_q <= fld.single;
                            seg_q    <= fld.single ? fld.seg : 2'b00;
                        end else if (verdict == V_ERROR && err_q != '1) begin
                            err_q <= err_q + 1'b1;
                        end
                    end
                end
                ST_LOAD: begin
                    if (beat && last_row) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                ST_FILL: begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cw_ready   = (state_q == ST_IDLE);
    assign blk_addr   = addr_q;
    assign op_type    = op_q;
    assign row_idx    = row_cur;
    assign row_valid  = step;
    assign fill_cmd   = (state_q == ST_FILL);
    assign fill_value = (op_q == OP_SET);
    assign seg_sel    = seg_q;
    assign single_ch  = single_q;
    assign op_done    = done_q;
    assign err_count  = err_q;

    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
        (cw_valid && cw_ready && (verdict == V_LOAD || verdict == V_FILL)) |=> !cw_ready); // R1

    AST_TAG_DROP: assert property (@(posedge clk) disable iff (rst)
        (cw_valid && cw_ready && fld.tag != '0) |=> (cw_ready && !fill_cmd && err_count == $past(err_count))); // R2

    AST_ROW_RANGE: assert property (@(posedge clk) disable iff (rst)
        row_valid |-> (row_idx >= ROW_W'(1) && int'(row_idx) <= ROWS)); // R4

    AST_FILL_DONE: assert property (@(posedge clk) disable iff (rst)
        fill_cmd |=> (op_done && cw_ready && !fill_cmd)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        op_done |=> !op_done); // R7

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cw_valid && cw_ready) |=> $stable(err_count)); // R8

    AST_ERR_NO_DROP: assert property (@(posedge clk) disable iff (rst)
        (cw_valid && cw_ready) |=> (err_count >= $past(err_count))); // R8

    AST_SEG_GATED: assert property (@(posedge clk) disable iff (rst)
        !single_ch |-> (seg_sel == 2'b00)); // R9

endmodule

// File: tb/blkctl_seq_tb.sv
`timescale 1ns/1ps
module blkctl_seq_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [191:0] cw_data = '0;
    logic         cw_valid = 1'b0;
    logic         cw_ready;
    logic         beat = 1'b0;
    logic [3:0]   blk_addr;
    logic [1:0]   op_type;
    logic [7:0]   row_idx;
    logic         row_valid;
    logic         fill_cmd;
    logic         fill_value;
    logic [1:0]   seg_sel;
    logic         single_ch;
    logic         op_done;
    logic [7:0]   err_count;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_err = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    blkctl_seq u_dut (
        .clk(clk), .rst(rst), .cw_data(cw_data), .cw_valid(cw_valid),
        .cw_ready(cw_ready), .beat(beat), .blk_addr(blk_addr), .op_type(op_type),
        .row_idx(row_idx), .row_valid(row_valid), .fill_cmd(fill_cmd),
        .fill_value(fill_value), .seg_sel(seg_sel), .single_ch(single_ch),
        .op_done(op_done), .err_count(err_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic logic [191:0] mk(input int tag, input int addr, input int cnt,
                                        input int lt, input int flip, input int seg,
                                        input int single);
        logic [191:0] w;
        w = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
        w[7:0]   = tag[7:0];
        w[11:8]  = addr[3:0];
        w[24:16] = cnt[8:0];
        w[29:28] = seg[1:0];
        w[30]    = single[0];
        w[34:32] = lt[2:0];
        w[36]    = flip[0];
        return w;
    endfunction

    // 0 silent drop, 1 error drop, 2 load, 3 fill
    function automatic int kind_of(input int tag, input int cnt, input int lt);
        if (tag != 0) return 0;
        if (lt == 0) return (cnt >= 1 && cnt <= 136) ? 2 : 1;
        if (lt == 1 || lt == 2) return 3;
        return 1;
    endfunction

    // Called at a falling edge with the block idle; returns at a falling edge, idle.
    task automatic do_op(input int tag, input int addr, input int cnt, input int lt,
                         input int flip, input int seg, input int single,
                         input int max_gap, input bit busy_offer);
        int kind;
        int exp_row;
        int exp_seg;
        kind    = kind_of(tag, cnt, lt);
        exp_seg = single ? seg : 0;
        cw_data  = mk(tag, addr, cnt, lt, flip, seg, single);
        cw_valid = 1'b1;
        #1 chk(cw_ready == 1'b1, "R1 ready when idle", int'(cw_ready), 1);
        @(negedge clk);
        cw_valid = 1'b0;
        #1;
        if (kind == 0 || kind == 1) begin
            if (kind == 1 && exp_err < 255) exp_err++;
            chk(cw_ready == 1'b1 && fill_cmd == 1'b0 && op_done == 1'b0,
                kind == 0 ? "R2 tag drop stays idle" : "R8 error drop stays idle",
                int'({cw_ready, fill_cmd, op_done}), 4);
            chk(int'(err_count) == exp_err, kind == 0 ? "R2 err unchanged" : "R8 err count",
                int'(err_count), exp_err);
            @(negedge clk);
        end else if (kind == 3) begin
            chk(fill_cmd == 1'b1, "R6 fill cmd", int'(fill_cmd), 1);
            chk(int'(fill_value) == (lt == 2 ? 1 : 0), "R6 fill value", int'(fill_value), lt == 2 ? 1 : 0);
            chk(int'(op_type) == lt, "R4 op type fill", int'(op_type), lt);
            chk(int'(blk_addr) == addr, "R3 block addr", int'(blk_addr), addr);
            chk(int'(seg_sel) == exp_seg && int'(single_ch) == single, "R9 segment",
                int'({single_ch, seg_sel}), single * 4 + exp_seg);
            chk(cw_ready == 1'b0, "R1 busy during fill", int'(cw_ready), 0);
            @(negedge clk);
            #1 chk(op_done == 1'b1 && cw_ready == 1'b1 && fill_cmd == 1'b0, "R7 fill done",
                   int'({op_done, cw_ready, fill_cmd}), 6);
            @(negedge clk);
            #1 chk(op_done == 1'b0 && fill_cmd == 1'b0, "R6 single fill pulse",
                   int'({op_done, fill_cmd}), 0);
        end else begin
            exp_row = flip ? 136 : 1;
            chk(int'(op_type) == 0, "R4 op type load", int'(op_type), 0);
            chk(int'(blk_addr) == addr, "R3 block addr", int'(blk_addr), addr);
            chk(int'(seg_sel) == exp_seg && int'(single_ch) == single, "R9 segment",
                int'({single_ch, seg_sel}), single * 4 + exp_seg);
            chk(cw_ready == 1'b0, "R1 busy during load", int'(cw_ready), 0);
            for (int i = 0; i < cnt; i++) begin
                int gaps;
                gaps = (max_gap > 0) ? int'($urandom_range(0, max_gap)) : 0;
                for (int g = 0; g < gaps; g++) begin
                    beat = 1'b0;
                    if (busy_offer) begin
                        cw_data  = mk(0, 0, 0, 2, 0, 0, 0);
                        cw_valid = 1'b1;
                    end
                    #1 chk(row_valid == 1'b0 && cw_ready == 1'b0 && int'(row_idx) == exp_row,
                           "R5 row holds in gap", int'(row_idx), exp_row);
                    @(negedge clk);
                    cw_valid = 1'b0;
                    #1 chk(fill_cmd == 1'b0, "R1 busy word not taken", int'(fill_cmd), 0);
                end
                beat = 1'b1;
                #1 chk(row_valid == 1'b1 && int'(row_idx) == exp_row, "R4 R5 row index",
                       int'(row_idx), exp_row);
                @(negedge clk);
                exp_row = flip ? exp_row - 1 : exp_row + 1;
            end
            beat = 1'b0;
            #1 chk(op_done == 1'b1 && cw_ready == 1'b1, "R7 load done",
                   int'({op_done, cw_ready}), 3);
            @(negedge clk);
            #1 chk(op_done == 1'b0 && fill_cmd == 1'b0, "R7 done is one pulse",
                   int'({op_done, fill_cmd}), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired at %0t", $time);
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(cw_ready == 1'b1 && op_done == 1'b0 && fill_cmd == 1'b0 && row_valid == 1'b0,
            "R1 reset state", int'({cw_ready, op_done, fill_cmd, row_valid}), 8);
        chk(err_count == 8'd0, "R8 reset err", int'(err_count), 0);
        @(negedge clk);

        // Directed corners
        do_op(0, 1, 1, 0, 0, 0, 0, 0, 0);     // single row upward
        do_op(0, 2, 1, 0, 1, 0, 0, 0, 0);     // single row downward
        do_op(0, 15, 136, 0, 0, 0, 0, 0, 0);  // full block upward
        do_op(0, 0, 136, 0, 1, 3, 1, 1, 1);   // full block downward, busy offers
        do_op(0, 7, 5, 0, 1, 2, 0, 2, 1);     // partial downward, segment gated off
        do_op(0, 9, 0, 1, 1, 1, 1, 0, 0);     // clear with count 0 and flip
        do_op(0, 4, 300, 2, 0, 2, 1, 0, 0);   // set with out-of-range count
        do_op(8'h5a, 3, 10, 0, 0, 0, 0, 0, 0);// tag nonzero
        do_op(8'h01, 3, 0, 5, 0, 0, 0, 0, 0); // tag beats error rule
        do_op(0, 3, 0, 0, 0, 0, 0, 0, 0);     // count 0
        do_op(0, 3, 137, 0, 0, 0, 0, 0, 0);   // count 137
        do_op(0, 3, 10, 3, 0, 0, 0, 0, 0);    // reserved type
        do_op(0, 3, 10, 7, 0, 0, 0, 0, 0);    // reserved type

        // Constrained random mix
        for (int n = 0; n < 80; n++) begin
            int sel, tag, cnt, lt;
            sel = int'($urandom_range(0, 9));
            tag = 0;
            lt  = 0;
            cnt = int'($urandom_range(1, 40));
            if (sel == 0) tag = int'($urandom_range(1, 255));
            else if (sel == 1) cnt = ($urandom_range(0, 1) == 0) ? 0 : int'($urandom_range(137, 511));
            else if (sel == 2) lt = int'($urandom_range(3, 7));
            else if (sel <= 4) begin
                lt  = int'($urandom_range(1, 2));
                cnt = int'($urandom_range(0, 511));
            end else if (sel == 5) cnt = int'($urandom_range(100, 136));
            do_op(tag, int'($urandom_range(0, 15)), cnt, lt, int'($urandom_range(0, 1)),
                  int'($urandom_range(0, 3)), int'($urandom_range(0, 1)),
                  int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)));
        end

        // Saturate the error counter
        for (int n = 0; n < 260; n++) begin
            do_op(0, 0, 0, 4 + (n % 4), 0, 0, 0, 0, 0);
        end
        #1 chk(err_count == 8'd255, "R8 saturation", int'(err_count), 255);
        do_op(0, 6, 3, 0, 0, 0, 0, 1, 0);    // still operates after saturation
        summary();
    end

endmodule